// File: doc/BRIEF.md
# Single-Wire Pulse-Width Brightness Command Decoder

This block listens to one input line that rests high and is pulled low by an external driver to send commands. The block measures how long each low pulse lasts, in microsecond ticks divided down from the system clock. The length of the pulse selects its meaning. A short pulse is a data 1. A medium pulse is a data 0. A very long pulse is a load command. Data bits shift into a 5-bit holding register with the most significant bit first. A load command copies the five most recent bits to the 5-bit brightness output and pulses a one-cycle done strobe.

The line first passes through a two-stage synchronizer. A controller with three states then walks each pulse through its phases:
- `ST_IDLE`: the line rests high.
- `ST_LOW`: a low pulse is being timed.
- `ST_GAP`: the line has gone high again and the block waits to see whether the high time is real.

The transitions are:
- `ST_IDLE`→`ST_LOW` on a falling line.
- `ST_LOW`→`ST_GAP` on a rising line.
- `ST_GAP`→`ST_LOW` if the line falls before the gap time expires. The block treats the short high as a glitch, and timing of the same low pulse continues.
- `ST_GAP`→`ST_IDLE` once the gap time expires. At that point the pulse is classified and acted upon.

While `enable` is low, every register is held cleared. The code therefore restarts at level 0 and stays there until a load command arrives.

Top module: `pwc_decoder`

## Requirements
- R1: A low pulse of 15 to 45 µs shifts a 1 into the holding register at bit 0, moving older bits up by one place.
- R2: A low pulse of 90 to 120 µs shifts a 0 into the holding register the same way.
- R3: A low pulse longer than 215 µs copies the holding register to `level_out`. Bit 4 of `level_out` is the oldest of the five most recent bits, so the bits 1,0,1,0,0 followed by a load give 5'b10100.
- R4: A low pulse whose length is in none of the three windows is ignored, and the holding register keeps its value.
- R5: A high time shorter than 3 µs between two low stretches is a glitch. The two low stretches are timed as one pulse.
- R6: While `enable` is low, `level_out`, the holding register and `load_done` are cleared. After `enable` rises, `level_out` stays 0 until a load command arrives.
- R7: `level_out` changes only in a cycle where `load_done` is high. `load_done` is high for exactly one cycle per load command.
- R8: The pulse timer saturates just above the load threshold, so a low of any length beyond 215 µs is still a load command.
- R9: When more than five bits arrive before a load, only the five most recent bits reach `level_out`. A load does not clear the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| enable | input | 1 | Active high; low clears every register |
| line_in | input | 1 | Command line, asynchronous, idles high |
| level_out | output | 5 | Loaded brightness code, 0 to 31 |
| load_done | output | 1 | One-cycle pulse when `level_out` is loaded |

## Verification
The decoder receives bit strings that separate the two data windows:
- all ones;
- 1,0,1,0,0, which checks the bit order;
- mixed codes.

Strings longer than five bits show that the oldest bits drop out. Out-of-window pulses fall into the gaps between the windows and on both sides of them, and a following load shows whether the holding register moved. A split pulse made of 20 µs low, 1 µs high and 80 µs low decodes to 0 only if the glitch is merged into the pulse; if the two parts were timed separately they would decode to a 1 and an ignored pulse. A 2000 µs load exercises the saturating timer. Dropping `enable` part way through shows that the partial bits are lost.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_GAP
    } pwc_state_e;

    typedef enum logic [1:0] {
        SYM_NONE,
        SYM_ONE,
        SYM_ZERO,
        SYM_LOAD
    } pwc_sym_e;

endpackage

// File: rtl/pwc_sync.sv
module pwc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic enable,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!enable) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], d_in};
        end
    end

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/pwc_tick.sv
module pwc_tick #(
    parameter int CLK_PER_US = 200
) (
    input  logic clk,
    input  logic enable,
    output logic tick
);
    localparam int DW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [DW-1:0] LAST = DW'(CLK_PER_US - 1);

    logic [DW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!enable) begin
            div_q <= '0;
            tick  <= 1'b0;
        end else if (div_q == LAST) begin
            div_q <= '0;
            tick  <= 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/pwc_classify.sv
module pwc_classify
    import pwc_pkg::*;
#(
    parameter int CW      = 8,
    parameter int ONE_LO  = 15,
    parameter int ONE_HI  = 45,
    parameter int ZERO_LO = 90,
    parameter int ZERO_HI = 120,
    parameter int LOAD_US = 215
) (
    input  logic [CW-1:0] low_cnt,
    output pwc_sym_e      sym
);
    always_comb begin
        if (low_cnt > CW'(LOAD_US)) begin
            sym = SYM_LOAD;
        end else if (low_cnt >= CW'(ONE_LO) && low_cnt <= CW'(ONE_HI)) begin
            sym = SYM_ONE;
        end else if (low_cnt >= CW'(ZERO_LO) && low_cnt <= CW'(ZERO_HI)) begin
            sym = SYM_ZERO;
        end else begin
            sym = SYM_NONE;
        end
    end
endmodule

// File: rtl/pwc_decoder.sv
module pwc_decoder
    import pwc_pkg::*;
#(
    parameter int CLK_PER_US = 200,
    parameter int CODE_W     = 5,
    parameter int ONE_LO     = 15,
    parameter int ONE_HI     = 45,
    parameter int ZERO_LO    = 90,
    parameter int ZERO_HI    = 120,
    parameter int LOAD_US    = 215,
    parameter int GAP_US     = 3
) (
    input  logic              clk,
    input  logic              enable,
    input  logic              line_in,
    output logic [CODE_W-1:0] level_out,
    output logic              load_done
);
    localparam int SAT = LOAD_US + 1;
    localparam int CW  = $clog2(SAT + 1);
    localparam int GW  = $clog2(GAP_US + 1);

    pwc_state_e        state_q, state_d;
    logic              line_s, line_low, tick, gap_done;
    logic [CW-1:0]     low_cnt;
    logic [GW-1:0]     gap_cnt;
    logic [CODE_W-1:0] shift_q;
    pwc_sym_e          sym;

    pwc_sync #(.STAGES(2)) u_sync (
        .clk(clk), .enable(enable), .d_in(line_in), .q_out(line_s)
    );

    pwc_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk(clk), .enable(enable), .tick(tick)
    );

    pwc_classify #(
        .CW(CW), .ONE_LO(ONE_LO), .ONE_HI(ONE_HI),
        .ZERO_LO(ZERO_LO), .ZERO_HI(ZERO_HI), .LOAD_US(LOAD_US)
    ) u_classify (
        .low_cnt(low_cnt), .sym(sym)
    );

    assign line_low = ~line_s;
    assign gap_done = (state_q == ST_GAP) && !line_low && tick
                      && (gap_cnt == GW'(GAP_US - 1));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (line_low) state_d = ST_LOW;
            ST_LOW:  if (!line_low) state_d = ST_GAP;
            ST_GAP: begin
                if (line_low)      state_d = ST_LOW;   // glitch: resume timing
                else if (gap_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!enable) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // counters, shift register and outputs
    always_ff @(posedge clk) begin
        if (!enable) begin
            low_cnt   <= '0;
            gap_cnt   <= '0;
            shift_q   <= '0;
            level_out <= '0;
            load_done <= 1'b0;
        end else begin
            load_done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    low_cnt <= '0;
                    gap_cnt <= '0;
                end
                ST_LOW: begin
                    gap_cnt <= '0;
                    if (tick && low_cnt != CW'(SAT)) low_cnt <= low_cnt + 1'b1;
                end
                ST_GAP: begin
                    if (line_low)  gap_cnt <= '0;
                    else if (tick) gap_cnt <= gap_cnt + 1'b1;
                    if (gap_done) begin
                        unique case (sym)
                            SYM_ONE:  shift_q <= {shift_q[CODE_W-2:0], 1'b1};
                            SYM_ZERO: shift_q <= {shift_q[CODE_W-2:0], 1'b0};
                            SYM_LOAD: begin
                                level_out <= shift_q;
                                load_done <= 1'b1;
                            end
                            SYM_NONE: ;
                            default: ;
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    // R7: output level moves only together with the strobe
    a_r7_level_with_strobe: assert property (@(posedge clk) disable iff (!enable)
        !$stable(level_out) |-> load_done);

    // R7: strobe lasts one cycle
    a_r7_strobe_one_cycle: assert property (@(posedge clk) disable iff (!enable)
        load_done |=> !load_done);

    // R8: pulse timer never passes its saturation value
    a_r8_timer_saturates: assert property (@(posedge clk) disable iff (!enable)
        low_cnt <= CW'(SAT));

    // R4: an unclassified pulse leaves the holding register alone
    a_r4_ignore_keeps_shift: assert property (@(posedge clk) disable iff (!enable)
        (gap_done && sym == SYM_NONE) |=> $stable(shift_q));

    // R6: disable clears everything on the next edge
    a_r6_disable_clears: assert property (@(posedge clk)
        !enable |=> (level_out == '0 && shift_q == '0 && !load_done));
endmodule

// File: tb/pwc_decoder_bench.sv
`timescale 1ns/1ps
module pwc_decoder_bench;
    localparam int K = 4;            // clocks per microsecond in the bench

    logic       clk = 1'b0;
    logic       enable = 1'b0;
    logic       line_in = 1'b1;
    logic [4:0] level_out;
    logic       load_done;

    int vectors = 0;
    int misses  = 0;
    int cycles  = 0;
    bit done    = 0;

    logic       q[$];               // received bits, oldest first
    logic [4:0] exp_level = '0;
    logic [4:0] pend_val  = '0;
    bit         pending   = 0;
    string      cur_req   = "R6";

    pwc_decoder #(.CLK_PER_US(K)) u_pwc_decoder (
        .clk(clk), .enable(enable), .line_in(line_in),
        .level_out(level_out), .load_done(load_done)
    );

    always #2.5 clk = ~clk;

    function automatic logic [4:0] model_code();
        logic [4:0] c = '0;
        for (int i = 0; i < 5; i++) begin
            int idx = q.size() - 5 + i;
            c[4-i] = (idx >= 0) ? q[idx] : 1'b0;
        end
        return c;
    endfunction

    // 0 none, 1 one, 2 zero, 3 load
    function automatic int model_kind(int us);
        if (us > 215) return 3;
        if (us >= 15 && us <= 45) return 1;
        if (us >= 90 && us <= 120) return 2;
        return 0;
    endfunction

    task automatic fail_msg(string req, int act, int expv);
        misses++;
        $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (!done) begin
            vectors++;
            if (load_done) begin
                if (!pending) fail_msg({cur_req, "/R7 stray strobe"}, 1, 0);
                else begin
                    if (level_out !== pend_val) fail_msg({cur_req, "/R3 loaded code"}, level_out, pend_val);
                    exp_level = pend_val;
                    pending = 0;
                end
            end else if (level_out !== exp_level) begin
                fail_msg({cur_req, "/R7 level"}, level_out, exp_level);
            end
            if (cycles == 150000) begin
                fail_msg("watchdog", cycles, 0);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
                $finish;
            end
        end
    end

    task automatic wait_us(int us);
        repeat (us * K) @(posedge clk);
        #1;
    endtask

    task automatic finish_pulse(int total_low, int high_us);
        int kind = model_kind(total_low);
        if (kind == 1) q.push_back(1'b1);
        if (kind == 2) q.push_back(1'b0);
        if (kind == 3) begin
            pend_val = model_code();
            pending = 1;
        end
        line_in = 1'b1;
        wait_us(high_us);
        if (pending) begin
            fail_msg({cur_req, "/R7 missing strobe"}, 0, 1);
            exp_level = pend_val;
            pending = 0;
        end
    endtask

    task automatic pulse(int low_us);
        line_in = 1'b0;
        wait_us(low_us);
        finish_pulse(low_us, 10);
    endtask

    task automatic send_bits(string s);
        for (int i = 0; i < s.len(); i++) pulse(s[i] == "1" ? 30 : 100);
    endtask

    task automatic expect_level(logic [4:0] v, string req);
        @(negedge clk);
        vectors++;
        if (level_out !== v) fail_msg(req, level_out, v);
    endtask

    initial begin
        wait_us(3);
        // R6: reset state
        enable = 1'b1;
        wait_us(2);
        expect_level(5'd0, "R6 reset level");
        vectors++;
        if (load_done !== 1'b0) fail_msg("R6 reset strobe", load_done, 0);

        cur_req = "R3";
        send_bits("10100"); pulse(300);
        expect_level(5'b10100, "R3 msb-first 10100");

        cur_req = "R1";
        send_bits("11111"); pulse(300);
        expect_level(5'd31, "R1 all ones");

        cur_req = "R2";
        send_bits("01101"); pulse(300);
        expect_level(5'd13, "R2 mixed code");

        cur_req = "R4";
        pulse(60); pulse(8); pulse(160); pulse(2); pulse(300);
        expect_level(5'd13, "R4 ignored pulses");

        cur_req = "R5";
        send_bits("1111");
        line_in = 1'b0; wait_us(20);
        line_in = 1'b1; wait_us(1);
        line_in = 1'b0; wait_us(80);
        finish_pulse(100, 10);
        pulse(300);
        expect_level(5'd30, "R5 glitch merged");

        cur_req = "R9";
        send_bits("1100101"); pulse(300);
        expect_level(5'd5, "R9 last five");

        cur_req = "R8";
        send_bits("10011"); pulse(2000);
        expect_level(5'd19, "R8 very long load");

        cur_req = "R6";
        send_bits("101");
        enable = 1'b0;
        @(posedge clk); #1;
        q.delete(); exp_level = '0;
        wait_us(5);
        enable = 1'b1;
        wait_us(2);
        expect_level(5'd0, "R6 cleared by enable");
        send_bits("11");
        expect_level(5'd0, "R6 holds until load");
        pulse(300);
        expect_level(5'd3, "R6 shift cleared");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule